// File: doc/BRIEF.md
# Sticky Interrupt Status and Mask Unit

This unit keeps the interrupt bookkeeping of an SD host controller. Event logic elsewhere in the controller (command, data path, DMA engine) raises one-cycle set pulses. Each pulse latches a bit into a sticky raw status word or into a DMA status word. A small card-detect state machine turns insert and remove pulses into two raw status flags that can never both be set, and into a card-present bit.

Software uses a simple word-addressed register port. It can program a global control word and an interrupt mask. It can read the raw status and the masked status, and it clears raw bits by writing ones to either of those two addresses. One level interrupt line is registered from the mask, the raw status and the global enable.

The card-detect state machine has two states. `CARD_IN` is the reset state. `CARD_OUT` is entered on the transition *remove* (a remove pulse with no insert pulse). `CARD_IN` is re-entered on the transition *insert* (an insert pulse with no remove pulse). Any other input leaves the state where it is.

Register addresses on `reg_addr`:
- 0: global control
- 1: mask
- 2: masked status
- 3: raw status
- 4: card status
- 5: DMA status

Every other address reads zero and ignores writes. A write to address 4 has no effect.

Top module: `isr_unit`

## Requirements
- R1: After reset, the registers read as follows: global control 0x00000300, mask 0, raw 0, masked 0, DMA status 0, card status 0x00000104 (with `rx_avail` low). `irq` is 0 and any unused address reads 0.
- R2: Address 2 reads the bitwise AND of the raw status and the mask (address 1).
- R3: A write to address 3 or address 2 clears every raw status bit written as 1 and leaves the other raw bits alone.
- R4: When `evt_set` and a software clear hit the same raw bit in one cycle, the bit ends up set.
- R5: `irq` is 1 exactly when global control bit 4 is set and (raw AND mask) is nonzero, as sampled one clock earlier. It is a register, so it follows any change of mask, enable or status by one cycle.
- R6: An insert pulse alone sets raw bit 30, clears raw bit 31 and sets card status bit 8. A remove pulse alone sets bit 31, clears bit 30 and clears bit 8. Both pulses together change nothing. `evt_set` bits 30 and 31 are ignored.
- R7: Global control bits 2, 1 and 0 always read 0. The other bits read back as written.
- R8: A write to address 5 clears only those bits among DMA status bits 9..0 that are written as 1. Bits 31..10 are never cleared. `dma_evt_set` sets bits sticky, and a set wins over a clear.
- R9: The card status read includes bit 17 when `rx_avail` is 1, and bit 2 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_set | input | 32 | One-cycle raw status set pulses |
| dma_evt_set | input | 32 | One-cycle DMA status set pulses |
| card_insert | input | 1 | Card insertion pulse |
| card_remove | input | 1 | Card removal pulse |
| rx_avail | input | 1 | Receive data available |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a collision. In it, a set pulse, a software clear and possibly a card event all land on the same status bit in the same cycle, and the interrupt line must then follow with a delay of exactly one register. Directed steps build that case on purpose. A clear of a just-pending bit is issued while the same bit is pulsed, and both card pulses are raised together. After that, several hundred cycles of sparse random events, writes and card pulses run against a behavioural model. The model is compared with the design on every clock, at whatever address the stimulus happens to present.

// File: rtl/isr_pkg.sv
package isr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_GCTL  = 3'd0,
        A_MASK  = 3'd1,
        A_MSTAT = 3'd2,
        A_RAW   = 3'd3,
        A_CARD  = 3'd4,
        A_DMA   = 3'd5
    } reg_addr_e;

    typedef enum logic {
        CARD_OUT = 1'b0,
        CARD_IN  = 1'b1
    } card_st_e;

    localparam int B_IRQ_EN  = 4;
    localparam int B_INS     = 30;
    localparam int B_REM     = 31;
    localparam int B_PRESENT = 8;
    localparam int B_RXAV    = 17;
    localparam int B_EMPTY   = 2;

    localparam logic [REG_W-1:0] GCTL_RST     = 32'h0000_0300;
    localparam logic [REG_W-1:0] GCTL_SELFCLR = 32'h0000_0007;
endpackage

// File: rtl/isr_card_fsm.sv
module isr_card_fsm
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins,
    input  logic rem,
    output logic present,
    output logic ins_evt,
    output logic rem_evt
);
    card_st_e st_q, st_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CARD_IN:  if (rem && !ins) st_d = CARD_OUT;   // transition: remove
            CARD_OUT: if (ins && !rem) st_d = CARD_IN;    // transition: insert
            default:  st_d = CARD_IN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CARD_IN;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        present = (st_q == CARD_IN);
        ins_evt = ins && !rem;
        rem_evt = rem && !ins;
    end

    // R6: a lone insert makes the card present, a lone remove makes it absent
    p_insert_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ins && !rem) |=> present);
    p_remove_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rem && !ins) |=> !present);
endmodule

// File: rtl/isr_w1c_bank.sv
module isr_w1c_bank #(
    parameter int          W        = 32,
    parameter logic [W-1:0] CLR_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] force_clr,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] KEEP_MASK = ~CLR_MASK;

    logic [W-1:0] q_d;

    always_comb q_d = ((q & ~(clr & CLR_MASK)) | set) & ~force_clr;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_d;
    end

    // R4/R8: a pulsed bit is set in the following cycle unless forced off
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        |(set & ~force_clr) |=> ((q & $past(set & ~force_clr)) == $past(set & ~force_clr)));

    generate
        if (KEEP_MASK != '0) begin : g_keep
            // R8: protected bits never fall while the block is out of reset
            p_high_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ((q & $past(q) & KEEP_MASK) == ($past(q) & KEEP_MASK)));
        end
    endgenerate
endmodule

// File: rtl/isr_unit.sv
module isr_unit
    import isr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] evt_set,
    input  logic [31:0] dma_evt_set,
    input  logic        card_insert,
    input  logic        card_remove,
    input  logic        rx_avail,
    output logic        irq
);
    localparam int DMA_CLR_BITS = 10;
    localparam logic [REG_W-1:0] DMA_CLR_MASK = REG_W'((64'd1 << DMA_CLR_BITS) - 64'd1);
    localparam logic [REG_W-1:0] CARD_BITS    = (REG_W'(1) << B_INS) | (REG_W'(1) << B_REM);

    reg_addr_e addr;
    logic [REG_W-1:0] gctl_q, mask_q, raw_q, dma_q;
    logic [REG_W-1:0] raw_set, raw_clr, raw_force, dma_clr, card_word;
    logic present, ins_evt, rem_evt;

    always_comb addr = reg_addr_e'(reg_addr);

    // Control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q <= GCTL_RST;
            mask_q <= '0;
        end else if (reg_wr) begin
            if (addr == A_GCTL) gctl_q <= reg_wdata & ~GCTL_SELFCLR;
            if (addr == A_MASK) mask_q <= reg_wdata;
        end
    end

    isr_card_fsm u_card (
        .clk     (clk),
        .rst_n   (rst_n),
        .ins     (card_insert),
        .rem     (card_remove),
        .present (present),
        .ins_evt (ins_evt),
        .rem_evt (rem_evt)
    );

    // Raw status set / clear sources
    always_comb begin
        raw_set   = (evt_set & ~CARD_BITS)
                  | (REG_W'(ins_evt) << B_INS)
                  | (REG_W'(rem_evt) << B_REM);
        raw_force = (REG_W'(ins_evt) << B_REM) | (REG_W'(rem_evt) << B_INS);
        raw_clr   = (reg_wr && (addr == A_RAW || addr == A_MSTAT)) ? reg_wdata : '0;
        dma_clr   = (reg_wr && addr == A_DMA) ? reg_wdata : '0;
    end

    isr_w1c_bank #(.W(REG_W), .CLR_MASK('1)) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (raw_set),
        .clr       (raw_clr),
        .force_clr (raw_force),
        .q         (raw_q)
    );

    isr_w1c_bank #(.W(REG_W), .CLR_MASK(DMA_CLR_MASK)) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (dma_evt_set),
        .clr       (dma_clr),
        .force_clr ('0),
        .q         (dma_q)
    );

    // Registered interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= gctl_q[B_IRQ_EN] && (|(raw_q & mask_q));
    end

    // Read mux
    always_comb begin
        card_word = (REG_W'(present) << B_PRESENT)
                  | (rx_avail ? (REG_W'(1) << B_RXAV) : (REG_W'(1) << B_EMPTY));
        unique case (addr)
            A_GCTL:  reg_rdata = gctl_q;
            A_MASK:  reg_rdata = mask_q;
            A_MSTAT: reg_rdata = raw_q & mask_q;
            A_RAW:   reg_rdata = raw_q;
            A_CARD:  reg_rdata = card_word;
            A_DMA:   reg_rdata = dma_q;
            default: reg_rdata = '0;
        endcase
    end

    // R5: the line is only raised under the global enable
    p_irq_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(gctl_q[B_IRQ_EN]));
    // R5: a pending unmasked bit under enable raises the line next cycle
    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q[B_IRQ_EN] && |(raw_q & mask_q)) |=> irq);
    // R6: the insert and remove flags are never both set
    p_card_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_q[B_INS] && raw_q[B_REM]));
    // R7: self-clearing control bits never hold a one
    p_gctl_selfclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gctl_q & GCTL_SELFCLR) == '0);
endmodule

// File: tb/test_isr_unit.sv
`timescale 1ns/100ps
module test_isr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] evt_set = '0;
    logic [31:0] dma_evt_set = '0;
    logic        card_insert = 1'b0;
    logic        card_remove = 1'b0;
    logic        rx_avail = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Behavioural model state
    logic [31:0] m_gctl, m_mask, m_raw, m_dma;
    logic        m_present, m_irq;

    always #2.5 clk = ~clk;

    isr_unit i_isr_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .dma_evt_set(dma_evt_set), .card_insert(card_insert),
        .card_remove(card_remove), .rx_avail(rx_avail), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_gctl;
            3'd1: return m_mask;
            3'd2: return m_raw & m_mask;
            3'd3: return m_raw;
            3'd4: return ({31'b0, m_present} << 8) | (rx_avail ? 32'h0002_0000 : 32'h0000_0004);
            3'd5: return m_dma;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag(logic [2:0] a);
        case (a)
            3'd0: return "R7";
            3'd1: return "R2";
            3'd2: return "R2";
            3'd3: return "R3";
            3'd4: return "R9";
            3'd5: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic model_reset();
        m_gctl = 32'h300; m_mask = 0; m_raw = 0; m_dma = 0; m_present = 1; m_irq = 0;
    endtask

    // One clock: update the model at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            m_irq = m_gctl[4] && ((m_raw & m_mask) != 0);
            if (reg_wr && reg_addr == 3'd0) m_gctl = reg_wdata & ~32'h7;
            if (reg_wr && reg_addr == 3'd1) m_mask = reg_wdata;
            if (reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3)) m_raw = m_raw & ~reg_wdata;
            m_raw = m_raw | (evt_set & 32'h3FFF_FFFF);
            if (card_insert && !card_remove) begin
                m_raw = (m_raw | 32'h4000_0000) & ~32'h8000_0000; m_present = 1;
            end
            if (card_remove && !card_insert) begin
                m_raw = (m_raw | 32'h8000_0000) & ~32'h4000_0000; m_present = 0;
            end
            if (reg_wr && reg_addr == 3'd5) m_dma = m_dma & ~(reg_wdata & 32'h3FF);
            m_dma = m_dma | dma_evt_set;
        end
        @(negedge clk);
        chk("R5 irq", {31'b0, irq}, {31'b0, m_irq});
        chk(tag(reg_addr), reg_rdata, m_read(reg_addr));
    endtask

    task automatic cyc(bit wr, logic [2:0] a, logic [31:0] d, logic [31:0] ev,
                       logic [31:0] dev, bit ins, bit rem);
        reg_wr = wr; reg_addr = a; reg_wdata = d; evt_set = ev;
        dma_evt_set = dev; card_insert = ins; card_remove = rem;
        tick();
        reg_wr = 0; evt_set = 0; dma_evt_set = 0; card_insert = 0; card_remove = 0;
    endtask

    task automatic rd(logic [2:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset values
        rd(3'd0, 32'h0000_0300, "R1 gctl");
        rd(3'd1, 32'h0, "R1 mask");
        rd(3'd2, 32'h0, "R1 masked");
        rd(3'd3, 32'h0, "R1 raw");
        rd(3'd4, 32'h0000_0104, "R1 card");
        rd(3'd5, 32'h0, "R1 dma");
        rd(3'd6, 32'h0, "R1 unused");
        chk("R1 irq", {31'b0, irq}, 32'h0);
        // R7 self-clearing control bits
        cyc(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(3'd0, 32'hFFFF_FFF8, "R7 gctl");
        cyc(1, 3'd0, 32'h0000_0010, 0, 0, 0, 0);
        // R2 masked view
        cyc(1, 3'd1, 32'h0000_00F0, 0, 0, 0, 0);
        cyc(0, 3'd3, 0, 32'h0000_0FF0, 0, 0, 0);
        chk("R5 one-cycle delay", {31'b0, irq}, 32'h0);
        rd(3'd2, 32'h0000_00F0, "R2 masked");
        rd(3'd3, 32'h0000_0FF0, "R2 raw");
        tick();
        chk("R5 raised", {31'b0, irq}, 32'h1);
        // R5 enable gating
        cyc(1, 3'd0, 32'h0, 0, 0, 0, 0);
        tick();
        chk("R5 disabled", {31'b0, irq}, 32'h0);
        cyc(1, 3'd0, 32'h10, 0, 0, 0, 0);
        // R3 clear via raw and masked addresses
        cyc(1, 3'd3, 32'h0000_0030, 0, 0, 0, 0);
        rd(3'd3, 32'h0000_0FC0, "R3 raw clear");
        cyc(1, 3'd2, 32'h0000_0F00, 0, 0, 0, 0);
        rd(3'd3, 32'h0000_00C0, "R3 masked clear");
        // R4 set wins
        cyc(1, 3'd3, 32'h0000_00C0, 32'h0000_0040, 0, 0, 0);
        rd(3'd3, 32'h0000_0040, "R4 set wins");
        // R6 card detect
        cyc(0, 3'd3, 0, 0, 0, 0, 1);
        rd(3'd3, 32'h8000_0040, "R6 remove raw");
        rd(3'd4, 32'h0000_0004, "R6 remove status");
        cyc(0, 3'd3, 0, 0, 0, 1, 0);
        rd(3'd3, 32'h4000_0040, "R6 insert raw");
        rd(3'd4, 32'h0000_0104, "R6 insert status");
        cyc(0, 3'd3, 0, 0, 0, 1, 1);
        rd(3'd3, 32'h4000_0040, "R6 both ignored");
        rd(3'd4, 32'h0000_0104, "R6 both status");
        cyc(0, 3'd3, 0, 32'hC000_0000, 0, 0, 0);
        rd(3'd3, 32'h4000_0040, "R6 evt bits ignored");
        // R8 DMA status protection
        cyc(0, 3'd5, 0, 0, 32'hFFFF_FFFF, 0, 0);
        cyc(1, 3'd5, 32'hFFFF_FFFF, 0, 0, 0, 0);
        rd(3'd5, 32'hFFFF_FC00, "R8 high bits kept");
        cyc(1, 3'd5, 32'h0000_0001, 0, 32'h0000_0001, 0, 0);
        rd(3'd5, 32'hFFFF_FC01, "R8 set wins");
        // R9 receive-available indication
        rx_avail = 1;
        rd(3'd4, 32'h0002_0100, "R9 rx avail");
        rx_avail = 0;
        rd(3'd4, 32'h0000_0104, "R9 empty");
        // Random phase against the model
        for (int i = 0; i < 600; i++) begin
            logic [2:0] a;
            a = 3'($urandom_range(0, 6));
            rx_avail = $urandom_range(0, 1) == 1;
            cyc(($urandom_range(0, 3) == 0), a, $urandom(),
                $urandom() & $urandom() & $urandom(),
                $urandom() & $urandom() & $urandom(),
                ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule